// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a byte-wide serial memory with 128K locations. It watches an oversampled, already synchronized clock line and data line and recognizes bus start and stop events. It matches the device select byte against two strap inputs and walks a state machine through the word address, write data and read data phases. The only thing it drives onto the bus is a pull-down enable for the open-drain data line. It acknowledges bytes on the ninth clock and shifts read data out most significant bit first.

On the memory side it has three connections. Read data comes from a synchronous port whose byte is valid one cycle after the read enable. Each accepted write byte goes to a page buffer as an address and data request. A single commit pulse at the stop event starts the internal write cycle. While the memory reports busy, the engine refuses to acknowledge its select byte, so a host can poll until the write cycle ends. A write-protect strap blocks all writes.

States: `ST_IDLE` (bus ignored), `ST_DEV` (select byte), `ST_DEV_ACK`, `ST_AHI` (high address byte), `ST_AHI_ACK`, `ST_ALO` (low address byte), `ST_ALO_ACK`, `ST_WDAT` (write byte), `ST_WDAT_ACK`, `ST_RDAT` (read byte out), `ST_RDAT_ACK` (host answer). A start event moves any state to `ST_DEV`, and a stop event moves any state to `ST_IDLE`. `ST_DEV` goes to `ST_DEV_ACK` on a match and to `ST_IDLE` otherwise. `ST_DEV_ACK` goes to `ST_RDAT` for a read and to `ST_AHI` for a write. The write path then runs `ST_AHI_ACK`, `ST_ALO`, `ST_ALO_ACK`, then `ST_WDAT`. `ST_WDAT` goes to `ST_WDAT_ACK`, or to `ST_IDLE` under write protect. `ST_WDAT_ACK` returns to `ST_WDAT`. `ST_RDAT` goes to `ST_RDAT_ACK` after eight bits. `ST_RDAT_ACK` goes back to `ST_RDAT` on a host ACK and to `ST_IDLE` on a host NACK.

Top module: `ee_twi_slave`

## Requirements
- R1: During reset and right after it, the SDA pull-down, the read enable, the write request and the commit pulse are all low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The select byte, sent MSB first, must carry 1010 in bits 7..4, the A2 strap in bit 3 and the A1 strap in bit 2. Any other select byte is not acknowledged, and all traffic is then ignored until the next start.
- R3: In a write, bit 1 of the select byte is address bit 16 and bit 0 is 0. The next byte is address bits 15..8, then bits 7..0.
- R4: Every accepted byte is acknowledged by pulling SDA low for the ninth SCL clock. The pull-down changes only while SCL is low.
- R5: A read select byte (bit 0 = 1) with no address phase returns the byte at the last accessed address plus one. Bit 1 of a read select byte does not affect the address.
- R6: A write select byte with two address bytes, then a repeated start and a read select byte, returns the byte at that 17-bit address.
- R7: After each host ACK in a read, the next byte is sent. The 17-bit address wraps from 0x1FFFF to 0x00000.
- R8: In a write, consecutive data bytes go to consecutive addresses. Only address bits 7..0 count up, wrapping inside their 256-byte page.
- R9: Each accepted data byte gives one write request with its address and data. One commit pulse follows a stop if at least one data byte was accepted since the start.
- R10: While busy is high, the select byte is not acknowledged.
- R11: While write protect is high, data bytes are not acknowledged and give no write request and no commit.
- R12: A start after accepted data bytes aborts the write, and no commit follows.
- R13: Read bytes go out MSB first, with the byte fetched before its first bit. A host NACK ends the read and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| sda_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| strap_a1_i | input | 1 | Device select strap compared with select bit 2 |
| strap_a2_i | input | 1 | Device select strap compared with select bit 3 |
| wp_i | input | 1 | Write protect strap |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_rd_en_o | output | 1 | Read enable, with data expected the next cycle |
| mem_rd_addr_o | output | 17 | Read address (the address counter) |
| mem_rd_data_i | input | 8 | Read data |
| wr_req_o | output | 1 | One-cycle write request to the page buffer |
| wr_addr_o | output | 17 | Write request address |
| wr_data_o | output | 8 | Write request data |
| wr_commit_o | output | 1 | One-cycle pulse that starts the internal write cycle |

## Verification
Byte writes to addresses spread across both halves of the array, each read back at random, show that select bit 1 and the two address bytes land in the right bits. Current-address reads, sequential reads across the top of the array and a page write that crosses byte offset 0xFF separate full-counter increments from page-local ones. Select bytes that are wrong in the tag or in a strap bit, bytes sent without a start after a refusal, and a busy memory each give no acknowledge. A protected write and a write aborted by a repeated start each show that no commit follows and the stored contents stay unchanged.

// File: rtl/ee_twi_pkg.sv
package ee_twi_pkg;
    localparam int EE_BYTE_W = 8;
    localparam int EE_ADDR_W = 2 * EE_BYTE_W + 1;
    localparam logic [3:0] EE_DEV_TAG = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } eng_state_t;

    typedef struct packed {
        logic [3:0] tag;
        logic       a2;
        logic       a1;
        logic       a16;
        logic       rd;
    } dev_byte_t;
endpackage

// File: rtl/ee_bus_cond.sv
module ee_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_rx_shift.sv
module ee_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         sample_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] cnt_q;

    assign full_o = (cnt_q == CNT_W'(W));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            data_o <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (sample_i && !full_o) begin
            data_o <= {data_o[W-2:0], bit_i};
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_page_i,
    input  logic              step_all_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= load_val_i;
        end else if (step_all_i) begin
            addr_o <= addr_o + 1'b1;
        end else if (step_page_i) begin
            addr_o[PAGE_W-1:0] <= addr_o[PAGE_W-1:0] + 1'b1;
        end
    end

    AST_PAGE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step_page_i && !load_i && !step_all_i) |->
        addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])); // R8
endmodule

// File: rtl/ee_twi_slave.sv
module ee_twi_slave
    import ee_twi_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_pull_o,
    input  logic                 strap_a1_i,
    input  logic                 strap_a2_i,
    input  logic                 wp_i,
    input  logic                 busy_i,
    output logic                 mem_rd_en_o,
    output logic [EE_ADDR_W-1:0] mem_rd_addr_o,
    input  logic [EE_BYTE_W-1:0] mem_rd_data_i,
    output logic                 wr_req_o,
    output logic [EE_ADDR_W-1:0] wr_addr_o,
    output logic [EE_BYTE_W-1:0] wr_data_o,
    output logic                 wr_commit_o
);
    localparam int BW    = EE_BYTE_W;
    localparam int AW    = EE_ADDR_W;
    localparam int TXC_W = $clog2(BW + 1);

    eng_state_t st_q, st_d;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic rx_clr, rx_full;
    logic [BW-1:0] rx_byte;
    logic ctr_ld, ctr_pg, ctr_all;
    logic [AW-1:0] ctr_addr, ctr_val;

    logic a16_q, rw_q, hack_q, pend_q, rd_valid_q;
    logic [BW-1:0] ahi_q, tx_sh_q, tx_d;
    logic [TXC_W-1:0] tx_cnt_q;
    logic fetch, wr_fire, hi_cap, dev_cap, tx_shift, tx_cnt_clr, pull_d;

    dev_byte_t dev;
    logic dev_hit;

    ee_bus_cond i_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    ee_rx_shift #(.W(BW)) i_rx (
        .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .sample_i(scl_rise),
        .bit_i(sda_i), .data_o(rx_byte), .full_o(rx_full)
    );

    ee_addr_ctr #(.ADDR_W(AW), .PAGE_W(PAGE_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(ctr_ld), .load_val_i(ctr_val),
        .step_page_i(ctr_pg), .step_all_i(ctr_all), .addr_o(ctr_addr)
    );

    assign dev     = dev_byte_t'(rx_byte);
    assign dev_hit = (dev.tag == EE_DEV_TAG) && (dev.a2 == strap_a2_i) &&
                     (dev.a1 == strap_a1_i) && !busy_i;
    assign ctr_val = {a16_q, ahi_q, rx_byte};
    assign mem_rd_addr_o = ctr_addr;

    // next state and control strobes
    always_comb begin
        st_d       = st_q;
        rx_clr     = 1'b0;
        ctr_ld     = 1'b0;
        ctr_pg     = 1'b0;
        ctr_all    = 1'b0;
        fetch      = 1'b0;
        wr_fire    = 1'b0;
        hi_cap     = 1'b0;
        dev_cap    = 1'b0;
        tx_shift   = 1'b0;
        tx_cnt_clr = 1'b0;
        if (start_det) begin
            st_d   = ST_DEV;
            rx_clr = 1'b1;
        end else if (stop_det) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_DEV: if (scl_fall && rx_full) begin
                    if (dev_hit) begin
                        st_d    = ST_DEV_ACK;
                        dev_cap = 1'b1;
                        fetch   = dev.rd;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                ST_DEV_ACK: if (scl_fall) begin
                    rx_clr     = 1'b1;
                    tx_cnt_clr = 1'b1;
                    st_d       = rw_q ? ST_RDAT : ST_AHI;
                end
                ST_AHI: if (scl_fall && rx_full) begin
                    st_d   = ST_AHI_ACK;
                    hi_cap = 1'b1;
                end
                ST_AHI_ACK: if (scl_fall) begin
                    rx_clr = 1'b1;
                    st_d   = ST_ALO;
                end
                ST_ALO: if (scl_fall && rx_full) begin
                    st_d   = ST_ALO_ACK;
                    ctr_ld = 1'b1;
                end
                ST_ALO_ACK: if (scl_fall) begin
                    rx_clr = 1'b1;
                    st_d   = ST_WDAT;
                end
                ST_WDAT: if (scl_fall && rx_full) begin
                    if (wp_i) begin
                        st_d = ST_IDLE;
                    end else begin
                        st_d    = ST_WDAT_ACK;
                        wr_fire = 1'b1;
                        ctr_pg  = 1'b1;
                    end
                end
                ST_WDAT_ACK: if (scl_fall) begin
                    rx_clr = 1'b1;
                    st_d   = ST_WDAT;
                end
                ST_RDAT: if (scl_fall) begin
                    if (tx_cnt_q == TXC_W'(BW)) begin
                        st_d    = ST_RDAT_ACK;
                        ctr_all = 1'b1;
                    end else begin
                        tx_shift = 1'b1;
                    end
                end
                ST_RDAT_ACK: begin
                    if (scl_rise && !sda_i) fetch = 1'b1;
                    if (scl_fall) begin
                        if (hack_q) begin
                            st_d       = ST_RDAT;
                            tx_cnt_clr = 1'b1;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_d = tx_sh_q;
        if (rd_valid_q)    tx_d = mem_rd_data_i;
        else if (tx_shift) tx_d = {tx_sh_q[BW-2:0], 1'b0};
    end

    always_comb begin
        unique case (st_d)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: pull_d = 1'b1;
            ST_RDAT: pull_d = ~tx_d[BW-1];
            default: pull_d = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a16_q      <= 1'b0;
            rw_q       <= 1'b0;
            ahi_q      <= '0;
            hack_q     <= 1'b0;
            tx_sh_q    <= '0;
            tx_cnt_q   <= '0;
            pend_q     <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            if (dev_cap) begin
                rw_q <= dev.rd;
                if (!dev.rd) a16_q <= dev.a16;
            end
            if (hi_cap) ahi_q <= rx_byte;
            if (st_q == ST_RDAT_ACK && scl_rise) hack_q <= ~sda_i;
            tx_sh_q    <= tx_d;
            rd_valid_q <= mem_rd_en_o;
            if (tx_cnt_clr) tx_cnt_q <= '0;
            else if (st_q == ST_RDAT && scl_rise) tx_cnt_q <= tx_cnt_q + 1'b1;
            if (start_det || stop_det) pend_q <= 1'b0;
            else if (wr_fire)          pend_q <= 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull_o  <= 1'b0;
            mem_rd_en_o <= 1'b0;
            wr_req_o    <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            wr_commit_o <= 1'b0;
        end else begin
            sda_pull_o  <= pull_d;
            mem_rd_en_o <= fetch;
            wr_req_o    <= wr_fire;
            wr_commit_o <= stop_det && pend_q;
            if (wr_fire) begin
                wr_addr_o <= ctr_addr;
                wr_data_o <= rx_byte;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_pull_o); // R2
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_i)); // R4
    AST_NO_WR_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !wp_i); // R11
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_det)); // R9
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEV_ACK && $past(st_q) == ST_DEV) |-> !$past(busy_i)); // R10
endmodule

// File: tb/test_ee_twi_slave.sv
module test_ee_twi_slave;
    localparam int H = 10;
    localparam int NV = 6;
    localparam logic [24:0] VEC [NV] = '{
        {17'h00005, 8'h11}, {17'h10005, 8'h22}, {17'h0ABCD, 8'h5A},
        {17'h1FF00, 8'hC3}, {17'h00000, 8'h7E}, {17'h1FFFF, 8'h99}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, scl_d = 1'b1, sda_d = 1'b1;
    logic a1 = 1'b0, a2 = 1'b1, wp = 1'b0, busy = 1'b0;
    logic sda_pull, rd_en, wr_req, wr_commit, sda_w;
    logic [16:0] rd_addr, wr_addr;
    logic [7:0] wr_data, rd_q;
    int errors = 0, checks = 0, commits = 0;
    bit finished = 1'b0;
    logic [7:0] mem [int];
    logic [7:0] stage [int];

    assign sda_w = sda_d & ~sda_pull;

    ee_twi_slave i_ee_twi_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_w), .sda_pull_o(sda_pull),
        .strap_a1_i(a1), .strap_a2_i(a2), .wp_i(wp), .busy_i(busy),
        .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_q),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
    );

    function automatic logic [7:0] dflt(int a);
        return 8'((a * 13) + (a >> 8) * 7 + (a >> 16) * 91);
    endfunction
    function automatic logic [7:0] mem_get(int a);
        if (mem.exists(a)) return mem[a];
        return dflt(a);
    endfunction

    always @(posedge clk) begin
        if (rd_en) rd_q <= mem_get(int'(rd_addr));
        if (wr_req) stage[int'(wr_addr)] = wr_data;
        if (wr_commit) begin
            foreach (stage[k]) mem[k] = stage[k];
            stage.delete();
            commits++;
        end
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic halfp(); repeat (H) @(negedge clk); endtask
    task automatic qtr(); repeat (H / 2) @(negedge clk); endtask

    task automatic i2c_start();
        stage.delete();
        sda_d = 1'b1; halfp(); scl_d = 1'b1; halfp(); sda_d = 1'b0; halfp(); scl_d = 1'b0;
    endtask
    task automatic i2c_stop();
        qtr(); sda_d = 1'b0; qtr(); scl_d = 1'b1; halfp(); sda_d = 1'b1; halfp();
    endtask
    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            qtr(); sda_d = b[i]; qtr(); scl_d = 1'b1; halfp(); scl_d = 1'b0;
        end
        qtr(); sda_d = 1'b1; qtr(); scl_d = 1'b1; qtr();
        ack = (sda_w == 1'b0);
        qtr(); scl_d = 1'b0;
    endtask
    task automatic recv_byte(output logic [7:0] b, input bit mack);
        sda_d = 1'b1; b = '0;
        for (int i = 0; i < 8; i++) begin
            halfp(); scl_d = 1'b1; qtr(); b = {b[6:0], sda_w}; qtr(); scl_d = 1'b0;
        end
        qtr(); sda_d = ~mack; qtr(); scl_d = 1'b1; halfp(); scl_d = 1'b0; qtr(); sda_d = 1'b1;
    endtask

    function automatic logic [7:0] devb(bit a16, bit rd);
        return {4'b1010, a2, a1, a16, rd};
    endfunction

    task automatic byte_write(int addr, logic [7:0] d, output bit ok);
        bit k0, k1, k2, k3;
        i2c_start();
        send_byte(devb(addr[16], 1'b0), k0);
        send_byte(addr[15:8], k1);
        send_byte(addr[7:0], k2);
        send_byte(d, k3);
        i2c_stop();
        ok = k0 & k1 & k2 & k3;
    endtask
    task automatic rand_setup(int addr, output bit ok);
        bit k0, k1, k2, k3;
        i2c_start();
        send_byte(devb(addr[16], 1'b0), k0);
        send_byte(addr[15:8], k1);
        send_byte(addr[7:0], k2);
        i2c_start();
        send_byte(devb(1'b0, 1'b1), k3);
        ok = k0 & k1 & k2 & k3;
    endtask
    task automatic rand_read(int addr, output logic [7:0] d);
        bit ok;
        rand_setup(addr, ok);
        recv_byte(d, 1'b0);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok, k;
        logic [7:0] d;
        int c0;
        repeat (4) @(negedge clk);
        check_eq("R1 pull in reset", int'(sda_pull), 0);
        check_eq("R1 outputs in reset", int'({rd_en, wr_req, wr_commit}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R1 pull after reset", int'(sda_pull), 0);

        // vector table: byte write then random read back
        for (int v = 0; v < NV; v++) begin
            c0 = commits;
            byte_write(int'(VEC[v][24:8]), VEC[v][7:0], ok);
            check_eq("R3 R4 write acks", int'(ok), 1);
            check_eq("R9 one commit", commits - c0, 1);
            rand_read(int'(VEC[v][24:8]), d);
            check_eq("R6 random read", int'(d), int'(VEC[v][7:0]));
        end
        check_eq("R3 A16 halves differ", int'(mem_get(32'h10005)), 8'h22);

        // R5 current address read
        rand_read(32'h0ABCD, d);
        i2c_start();
        send_byte(devb(1'b1, 1'b1), k);
        recv_byte(d, 1'b0);
        i2c_stop();
        check_eq("R5 current address ack", int'(k), 1);
        check_eq("R5 current address data", int'(d), int'(mem_get(32'h0ABCE)));

        // R7 sequential read across top of array
        rand_setup(32'h1FFFE, ok);
        recv_byte(d, 1'b1);
        check_eq("R7 seq byte 0", int'(d), int'(mem_get(32'h1FFFE)));
        recv_byte(d, 1'b1);
        check_eq("R7 seq byte 1", int'(d), 8'h99);
        recv_byte(d, 1'b0);
        check_eq("R7 seq wrap to 0", int'(d), 8'h7E);
        qtr();
        check_eq("R13 released after NACK", int'(sda_pull), 0);
        i2c_stop();

        // R8 page write wrap
        c0 = commits;
        i2c_start();
        send_byte(devb(1'b0, 1'b0), k);
        send_byte(8'h12, k);
        send_byte(8'hFE, k);
        send_byte(8'h01, k);
        send_byte(8'h02, k);
        send_byte(8'h03, k);
        i2c_stop();
        check_eq("R9 page commit", commits - c0, 1);
        rand_read(32'h012FE, d); check_eq("R8 page 0xFE", int'(d), 8'h01);
        rand_read(32'h012FF, d); check_eq("R8 page 0xFF", int'(d), 8'h02);
        rand_read(32'h01200, d); check_eq("R8 page wrap 0x00", int'(d), 8'h03);
        rand_read(32'h01300, d); check_eq("R8 next page untouched", int'(d), int'(dflt(32'h01300)));

        // R2 address mismatch and ignore until START
        i2c_start();
        send_byte({4'b1010, ~a2, a1, 2'b00}, k);
        check_eq("R2 strap mismatch nack", int'(k), 0);
        send_byte(devb(1'b0, 1'b0), k);
        check_eq("R2 ignored without start", int'(k), 0);
        i2c_stop();
        i2c_start();
        send_byte({4'b1011, a2, a1, 2'b00}, k);
        check_eq("R2 tag mismatch nack", int'(k), 0);
        i2c_stop();
        check_eq("R2 bus released", int'(sda_pull), 0);

        // R10 busy polling
        c0 = commits;
        busy = 1'b1;
        i2c_start(); send_byte(devb(1'b0, 1'b0), k); i2c_stop();
        check_eq("R10 busy nack", int'(k), 0);
        busy = 1'b0;
        i2c_start(); send_byte(devb(1'b0, 1'b0), k); i2c_stop();
        check_eq("R10 ack after busy", int'(k), 1);
        check_eq("R9 no commit without data", commits - c0, 0);

        // R11 write protect
        c0 = commits;
        wp = 1'b1;
        i2c_start();
        send_byte(devb(1'b0, 1'b0), k);
        send_byte(8'h00, k);
        send_byte(8'h40, k);
        send_byte(8'hEE, k);
        check_eq("R11 data nack", int'(k), 0);
        i2c_stop();
        wp = 1'b0;
        check_eq("R11 no commit", commits - c0, 0);
        rand_read(32'h00040, d);
        check_eq("R11 memory unchanged", int'(d), int'(dflt(32'h00040)));

        // R12 abort by repeated start
        c0 = commits;
        i2c_start();
        send_byte(devb(1'b0, 1'b0), k);
        send_byte(8'h00, k);
        send_byte(8'h80, k);
        send_byte(8'h55, k);
        check_eq("R12 data acked", int'(k), 1);
        i2c_start();
        i2c_stop();
        check_eq("R12 no commit after abort", commits - c0, 0);
        rand_read(32'h00080, d);
        check_eq("R12 memory unchanged", int'(d), int'(dflt(32'h00080)));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule